// File: doc/BRIEF.md
# Line Sync and Interrupt Timing Generator

This block paces a raster display from a fast master clock. A free-running counter divides the clock into scan lines, and a horizontal sync pulse is raised at the start of every line. A periodic non-maskable interrupt can be enabled to mark each line for the CPU. When it is enabled, the active-low interrupt output pulses during exactly the same clocks as the horizontal sync. The CPU turns this interrupt on and off by writing to two I/O ports.

Vertical sync is under software control. A read from an even I/O port forces the video output to the sync level and holds the 3-bit scan-line counter at zero. Any I/O write then releases it. The read has no effect while the interrupt is enabled. The block emits a two-bit video level code: sync, black when the pixel input is set, and white otherwise. All outputs are registered.

Top module: `sync_nmi_gen`

## Requirements
- R1: After reset the outputs are video_lvl = 2'b10 (white), nmi_n = 1, line_rst = 0 and line_cnt = 0, and the interrupt generator is disabled.
- R2: Each line lasts LINE_CLKS (416) clocks. During its first HS_CLKS (32) clocks, video_lvl is 2'b00 (sync), one clock after the line counter value. Outside vertical sync this repeats with no CPU access.
- R3: Outside sync, video_lvl is 2'b01 (black) when pix_black was high on the previous clock and 2'b10 (white) when it was low. The code 2'b11 never appears.
- R4: A write access is iorq_n = 0, wr_n = 0 and m1_n = 1. A write to address 8'hFE enables the interrupt generator, and a write to 8'hFD disables it.
- R5: While enabled, nmi_n is low on exactly the clocks where video_lvl shows horizontal sync, which gives one pulse per line. While disabled, nmi_n stays high.
- R6: A read access is iorq_n = 0, rd_n = 0 and m1_n = 1. A read at an address with bit 0 = 0, made while the interrupt is disabled, sets line_rst on the next clock. Every clock after that, video_lvl is 2'b00 for as long as line_rst stays high.
- R7: A read is ignored when the interrupt is enabled, when address bit 0 = 1, or when m1_n = 0. In each of these cases line_rst stays 0.
- R8: Any write access, to any address, clears line_rst on the next clock.
- R9: The clock after a horizontal sync pulse ends (after the counter leaves the last sync clock), line_cnt increments by one, modulo 8. While line_rst is high, line_cnt is forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| io_addr | input | 8 | Low byte of the CPU address during I/O access |
| iorq_n | input | 1 | I/O request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch / interrupt acknowledge, active low |
| pix_black | input | 1 | Pixel from the shift path, 1 = black |
| video_lvl | output | 2 | Video level: 00 sync, 01 black, 10 white |
| nmi_n | output | 1 | Per-line interrupt, active low |
| line_rst | output | 1 | Scan-line counter reset (vertical sync active) |
| line_cnt | output | 3 | Scan-line counter |

## Verification
The assertions assume that the CPU strobes are stable around each clock edge. They also assume that a read and a write are never asserted together. The bench drives every input on the falling edge and issues each access as a single clock of strobes, so both conditions hold. Rejected reads are presented with the interrupt enabled, with an odd address, and with m1_n low. Vertical sync is held for longer than one line, so the counter clamp and the free-running line timing both overlap it.

// File: rtl/snm_pkg.sv
package snm_pkg;
  typedef enum logic [1:0] {
    LVL_SYNC  = 2'b00,
    LVL_BLACK = 2'b01,
    LVL_WHITE = 2'b10
  } vid_lvl_e;
endpackage

// File: rtl/snm_line_timer.sv
module snm_line_timer #(
  parameter int unsigned LINE_CLKS = 416,
  parameter int unsigned HS_CLKS   = 32,
  localparam int unsigned CW = $clog2(LINE_CLKS)
) (
  input  logic clk,
  input  logic rst,
  output logic hs_active,
  output logic hs_last
);
  logic [CW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst)                             hcnt <= '0;
    else if (hcnt == CW'(LINE_CLKS - 1)) hcnt <= '0;
    else                                 hcnt <= hcnt + 1'b1;
  end

  assign hs_active = (hcnt < CW'(HS_CLKS));
  assign hs_last   = (hcnt == CW'(HS_CLKS - 1));
endmodule

// File: rtl/snm_io_ctrl.sv
module snm_io_ctrl #(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned PORT_NMI_OFF = 'hFD,
  parameter int unsigned PORT_NMI_ON  = 'hFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              m1_n,
  output logic              nmi_en,
  output logic              vsync
);
  logic wr_acc, rd_acc;

  assign wr_acc = !iorq_n && !wr_n && m1_n;
  assign rd_acc = !iorq_n && !rd_n && m1_n && !io_addr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_en <= 1'b0;
      vsync  <= 1'b0;
    end else if (wr_acc) begin
      vsync <= 1'b0;
      if (io_addr == ADDR_W'(PORT_NMI_OFF))     nmi_en <= 1'b0;
      else if (io_addr == ADDR_W'(PORT_NMI_ON)) nmi_en <= 1'b1;
    end else if (rd_acc && !nmi_en) begin
      vsync <= 1'b1;
    end
  end
endmodule

// File: rtl/snm_scan_cnt.sv
module snm_scan_cnt #(
  parameter int unsigned LCNT_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              step,
  output logic [LCNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/snm_out_stage.sv
module snm_out_stage
  import snm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       hs_active,
  input  logic       vsync,
  input  logic       nmi_en,
  input  logic       pix_black,
  output logic [1:0] video_lvl,
  output logic       nmi_n
);
  vid_lvl_e lvl_d;

  always_comb begin
    if (vsync || hs_active) lvl_d = LVL_SYNC;
    else if (pix_black)     lvl_d = LVL_BLACK;
    else                    lvl_d = LVL_WHITE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      video_lvl <= LVL_WHITE;
      nmi_n     <= 1'b1;
    end else begin
      video_lvl <= lvl_d;
      nmi_n     <= !(nmi_en && hs_active);
    end
  end
endmodule

// File: rtl/sync_nmi_gen.sv
module sync_nmi_gen #(
  parameter int unsigned LINE_CLKS    = 416,
  parameter int unsigned HS_CLKS      = 32,
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned PORT_NMI_OFF = 'hFD,
  parameter int unsigned PORT_NMI_ON  = 'hFE,
  parameter int unsigned LCNT_W       = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              m1_n,
  input  logic              pix_black,
  output logic [1:0]        video_lvl,
  output logic              nmi_n,
  output logic              line_rst,
  output logic [LCNT_W-1:0] line_cnt
);
  logic hs_active, hs_last, nmi_en, vsync;

  snm_line_timer #(.LINE_CLKS(LINE_CLKS), .HS_CLKS(HS_CLKS)) u_timer (
    .clk(clk), .rst(rst), .hs_active(hs_active), .hs_last(hs_last)
  );

  snm_io_ctrl #(.ADDR_W(ADDR_W), .PORT_NMI_OFF(PORT_NMI_OFF),
                .PORT_NMI_ON(PORT_NMI_ON)) u_io (
    .clk(clk), .rst(rst), .io_addr(io_addr), .iorq_n(iorq_n), .rd_n(rd_n),
    .wr_n(wr_n), .m1_n(m1_n), .nmi_en(nmi_en), .vsync(vsync)
  );

  snm_scan_cnt #(.LCNT_W(LCNT_W)) u_scan (
    .clk(clk), .rst(rst), .clr(vsync), .step(hs_last), .cnt(line_cnt)
  );

  snm_out_stage u_out (
    .clk(clk), .rst(rst), .hs_active(hs_active), .vsync(vsync),
    .nmi_en(nmi_en), .pix_black(pix_black), .video_lvl(video_lvl), .nmi_n(nmi_n)
  );

  assign line_rst = vsync;
endmodule

// File: rtl/snm_checker.sv
module snm_checker #(
  parameter int unsigned LCNT_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              iorq_n,
  input logic              wr_n,
  input logic              m1_n,
  input logic [1:0]        video_lvl,
  input logic              nmi_n,
  input logic              line_rst,
  input logic [LCNT_W-1:0] line_cnt
);
  // R5
  nmi_in_sync_chk: assert property (@(posedge clk) disable iff (rst)
    !nmi_n |-> video_lvl == 2'b00);

  // R3
  lvl_code_chk: assert property (@(posedge clk) disable iff (rst)
    video_lvl != 2'b11);

  // R6
  vsync_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    line_rst |=> video_lvl == 2'b00);

  // R8
  vsync_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!iorq_n && !wr_n && m1_n) |=> !line_rst);

  // R9
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (line_rst && $past(line_rst)) |-> line_cnt == '0);

  // R9
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_cnt) |-> (line_cnt == $past(line_cnt) + 1'b1 || line_cnt == '0));
endmodule

bind sync_nmi_gen snm_checker #(.LCNT_W(LCNT_W)) u_chk (
  .clk(clk), .rst(rst), .iorq_n(iorq_n), .wr_n(wr_n), .m1_n(m1_n),
  .video_lvl(video_lvl), .nmi_n(nmi_n), .line_rst(line_rst), .line_cnt(line_cnt)
);

// File: tb/sync_nmi_gen_tb.sv
module sync_nmi_gen_tb;
  localparam int LINE = 416;
  localparam int HS   = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] io_addr = 8'h00;
  logic       iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
  logic       pix_black = 1'b0;
  logic [1:0] video_lvl;
  logic       nmi_n, line_rst;
  logic [2:0] line_cnt;

  int n_tests = 0;
  int n_fail  = 0;
  int nmi_pulses = 0;
  logic nmi_prev = 1'b1;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int mh = 0, mlc = 0;
  bit men = 0, mvs = 0;
  int ev = 2;
  bit enmi = 1;

  always #5 clk = ~clk;

  sync_nmi_gen u_dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .iorq_n(iorq_n), .rd_n(rd_n),
    .wr_n(wr_n), .m1_n(m1_n), .pix_black(pix_black), .video_lvl(video_lvl),
    .nmi_n(nmi_n), .line_rst(line_rst), .line_cnt(line_cnt)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference, stepped on every rising edge
  always @(posedge clk) begin
    bit hs, wr, rd;
    int nlc;
    if (rst) begin
      mh = 0; mlc = 0; men = 0; mvs = 0; ev = 2; enmi = 1;
    end else begin
      hs   = (mh < HS);
      ev   = (mvs || hs) ? 0 : (pix_black ? 1 : 2);
      enmi = !(men && hs);
      nlc  = mvs ? 0 : ((mh == HS - 1) ? (mlc + 1) % 8 : mlc);
      wr   = !iorq_n && !wr_n && m1_n;
      rd   = !iorq_n && !rd_n && m1_n;
      if (wr) begin
        mvs = 0;
        if (io_addr == 8'hFD) men = 0;
        else if (io_addr == 8'hFE) men = 1;
      end else if (rd && !io_addr[0] && !men) begin
        mvs = 1;
      end
      mlc = nlc;
      mh  = (mh + 1) % LINE;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(int'(video_lvl) == ev, "R2/R3/R6 video_lvl", int'(video_lvl), ev);
      chk(nmi_n == enmi, "R5 nmi_n", int'(nmi_n), int'(enmi));
      chk(line_rst == mvs, "R6/R7/R8 line_rst", int'(line_rst), int'(mvs));
      chk(int'(line_cnt) == mlc, "R9 line_cnt", int'(line_cnt), mlc);
    end
    if (nmi_prev && !nmi_n) nmi_pulses++;
    nmi_prev = nmi_n;
  end

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pix_black = lfsr[0];
    end
  endtask

  task automatic io_wr(input logic [7:0] a);
    @(negedge clk);
    io_addr = a; iorq_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    iorq_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic io_rd(input logic [7:0] a, input logic m1);
    @(negedge clk);
    io_addr = a; iorq_n = 1'b0; rd_n = 1'b0; m1_n = m1;
    @(negedge clk);
    iorq_n = 1'b1; rd_n = 1'b1; m1_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(video_lvl == 2'b10, "R1 reset video", int'(video_lvl), 2);
    chk(nmi_n == 1'b1, "R1 reset nmi_n", int'(nmi_n), 1);
    chk(line_rst == 1'b0, "R1 reset line_rst", int'(line_rst), 0);
    chk(line_cnt == 3'd0, "R1 reset line_cnt", int'(line_cnt), 0);
    rst = 1'b0;
    run(2 * LINE);
    // R5: disabled generator gives no pulses
    chk(nmi_pulses == 0, "R5 no pulses while disabled", nmi_pulses, 0);
    // R4: enable, count pulses over three lines
    io_wr(8'hFE);
    run(LINE);
    nmi_pulses = 0;
    run(3 * LINE);
    chk(nmi_pulses == 3, "R4/R5 one pulse per line", nmi_pulses, 3);
    // R7: read while enabled is ignored
    io_rd(8'hFE, 1'b1);
    run(3);
    chk(line_rst == 1'b0, "R7 read ignored when enabled", int'(line_rst), 0);
    // R4: disable
    io_wr(8'hFD);
    run(LINE);
    nmi_pulses = 0;
    run(2 * LINE);
    chk(nmi_pulses == 0, "R4 disabled by FD", nmi_pulses, 0);
    // R7: odd address and m1_n low are ignored
    io_rd(8'hFF, 1'b1);
    run(3);
    chk(line_rst == 1'b0, "R7 odd address read ignored", int'(line_rst), 0);
    io_rd(8'hFE, 1'b0);
    run(3);
    chk(line_rst == 1'b0, "R7 m1_n low read ignored", int'(line_rst), 0);
    // R6: vertical sync held longer than a line
    io_rd(8'h7E, 1'b1);
    run(LINE + 100);
    chk(line_rst == 1'b1, "R6 vsync held", int'(line_rst), 1);
    chk(video_lvl == 2'b00, "R6 video clamped", int'(video_lvl), 0);
    chk(line_cnt == 3'd0, "R9 counter held", int'(line_cnt), 0);
    // R8: any write ends it
    io_wr(8'h55);
    run(2);
    chk(line_rst == 1'b0, "R8 write ends vsync", int'(line_rst), 0);
    // R9/R2: run past a counter wrap
    run(10 * LINE);
    // R8 with the enable port also ends vsync and enables
    io_rd(8'h00, 1'b1);
    run(50);
    io_wr(8'hFE);
    run(3 * LINE);
    io_wr(8'hFD);
    run(LINE);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule